// File: doc/BRIEF.md
# NAND Read Prefetch Engine

This block moves a programmed number of bytes from a byte-wide NAND read port into a 64-byte on-chip FIFO, and hands them to a host as 32-bit words. Software first sets up two configuration registers and then writes the control register to start the engine. One register holds the direction, the enable, the FIFO threshold and the chip select. The other holds the byte count. While the engine runs, it requests bytes whenever there is room in the FIFO and bytes are still owed. The host polls a status register that reports the bytes still to fetch, the FIFO fill level, a threshold flag and a sticky error bit. The host then reads as many words as the fill level allows.

The engine protects a running transfer by refusing configuration writes and flagging each refused write. Writing zero to the control register aborts a transfer at any time. It discards the buffered bytes and returns the engine to idle, ready to be set up again.

Top module: `nand_rd_prefetch`

## Requirements
- R1: Registers sit at word addresses 0 (setup), 1 (length), 2 (control) and 3 (status). The setup register reads back direction at bit 0, enable at bit 7, threshold at bits 15:8 and chip select at bits 24 and up, with only the chip-select width stored and every other bit zero. The length register reads back the byte count in bits 13:0. All registers read zero after reset.
- R2: A setup write whose threshold field (bits 15:8) exceeds 64 is refused: the setup register keeps its old value and the error bit is set.
- R3: Writing the control register with bit 0 = 1 starts a transfer only if the engine is idle, the enable bit is 1 and the direction bit is 0. A start loads the remaining count from the length register, and control then reads 1. Otherwise the write has no effect.
- R4: While the engine is busy, writes to the setup or length register are ignored and the sticky error bit (status bit 15) is set.
- R5: While busy, the engine asserts the NAND request whenever bytes remain and the FIFO is not full. Each cycle with both request and acknowledge stores one byte and decrements the remaining count by one. The chip-select output equals the stored chip-select field.
- R6: A host word is available when the FIFO holds at least 4 bytes, or when no bytes remain to fetch and the FIFO is not empty. The oldest byte is in bits 7:0 (little-endian). A short final word is zero-filled in its upper bytes. A host read removes the bytes of the word, and a host read with no word available is ignored.
- R7: Status bits 13:0 give the remaining byte count and bits 30:24 give the FIFO fill level. Bit 15 is the error flag. Bit 14 is 1 when the threshold is non-zero and the fill level is at or above it. All other bits are zero.
- R8: A busy engine returns to idle (control reads 0) one clock after the remaining count and the FIFO level are both zero.
- R9: Writing the control register with bit 0 = 0 stops the engine, empties the FIFO, clears the remaining count and clears the error bit.
- R10: The FIFO level never exceeds 64. With no host reads, fetching pauses at a level of exactly 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Register write address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 2 | Register read address |
| reg_rdata | output | 32 | Register read data (combinational) |
| host_rd | input | 1 | Host word read / pop |
| host_word | output | 32 | Head word of the FIFO, little-endian |
| host_word_ok | output | 1 | A host word is available |
| nand_req | output | 1 | Request for one byte from the NAND port |
| nand_ack | input | 1 | NAND port delivers a byte this cycle |
| nand_data | input | 8 | Byte from the NAND port |
| nand_cs | output | 3 | Selected chip |

## Verification
A register write shows on the read port in the first cycle after the clock edge that captured it. A start or stop takes effect at that same edge. A byte accepted at an edge, and a word popped at an edge, show in the remaining count and the fill level right after that edge. The return to idle comes one edge after the engine has drained. The bench drives inputs and samples all outputs on the falling edge. Its NAND model counts an accepted byte only at the falling edge that follows the rising edge where the transfer happened, so its expected remaining count and fill level match the design's in every cycle. It compares the full status word on every cycle of each transfer, and it checks the idle state two cycles after the last pop.

// File: rtl/pf_pkg.sv
// Package: shared register addresses and bit positions of the prefetch engine.
// Assumes a 2-bit word address space with four registers.
package pf_pkg;
    typedef enum logic [1:0] {
        PF_SETUP = 2'd0,
        PF_LEN   = 2'd1,
        PF_CTRL  = 2'd2,
        PF_STAT  = 2'd3
    } pf_addr_e;

    localparam int unsigned DIR_BIT  = 0;
    localparam int unsigned EN_BIT   = 7;
    localparam int unsigned THR_LSB  = 8;
    localparam int unsigned THR_FLD  = 8;
    localparam int unsigned SEL_LSB  = 24;
    localparam int unsigned LVL_LSB  = 24;
    localparam int unsigned ERR_BIT  = 15;
    localparam int unsigned HIT_BIT  = 14;
endpackage

// File: rtl/pf_regs.sv
// Module: pf_regs
// Holds the setup and length registers, the run state and the sticky error.
// Assumes one register write per cycle; refuses setup changes while running.
module pf_regs
    import pf_pkg::*;
#(
    parameter int unsigned CNT_W   = 14,
    parameter int unsigned SEL_W   = 3,
    parameter int unsigned THR_MAX = 64,
    localparam int unsigned THR_W  = $clog2(THR_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [31:0]      wr_data,
    input  logic             drained,
    output logic             running,
    output logic             start,
    output logic             stop,
    output logic             dir_q,
    output logic             en_q,
    output logic [THR_W-1:0] thr_q,
    output logic [SEL_W-1:0] sel_q,
    output logic [CNT_W-1:0] len_q,
    output logic             err_q
);
    logic wr_setup, wr_len, wr_ctrl, thr_bad;

    // Decode the write strobe per register.
    always_comb begin
        wr_setup = wr_en && (wr_addr == PF_SETUP);
        wr_len   = wr_en && (wr_addr == PF_LEN);
        wr_ctrl  = wr_en && (wr_addr == PF_CTRL);
        thr_bad  = wr_data[THR_LSB +: THR_FLD] > THR_FLD'(THR_MAX);
        start    = wr_ctrl && wr_data[0] && !running && en_q && !dir_q;
        stop     = wr_ctrl && !wr_data[0];
    end

    // Setup register: accepted only when idle and the threshold is legal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= 1'b0;
            en_q  <= 1'b0;
            thr_q <= '0;
            sel_q <= '0;
        end else if (wr_setup && !running && !thr_bad) begin
            dir_q <= wr_data[DIR_BIT];
            en_q  <= wr_data[EN_BIT];
            thr_q <= wr_data[THR_LSB +: THR_W];
            sel_q <= wr_data[SEL_LSB +: SEL_W];
        end
    end

    // Length register: accepted only when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
        end else if (wr_len && !running) begin
            len_q <= wr_data[CNT_W-1:0];
        end
    end

    // Run state: stop wins, then start, then drain completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
        end else if (stop) begin
            running <= 1'b0;
        end else if (start) begin
            running <= 1'b1;
        end else if (running && drained) begin
            running <= 1'b0;
        end
    end

    // Sticky error: set by any refused setup or length write, cleared by stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (stop) begin
            err_q <= 1'b0;
        end else if ((wr_setup && (running || thr_bad)) || (wr_len && running)) begin
            err_q <= 1'b1;
        end
    end

    // R4
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> ($stable(thr_q) && $stable(sel_q) && $stable(len_q)
                     && $stable(en_q) && $stable(dir_q)));

    // R4
    busy_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && wr_en && (wr_addr == PF_SETUP || wr_addr == PF_LEN)) |=> err_q);

    // R2
    thr_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thr_q <= THR_W'(THR_MAX));

    // R9
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!running && !err_q));
endmodule

// File: rtl/pf_fetch.sv
// Module: pf_fetch
// Tracks the bytes still owed and raises the NAND byte request.
// Assumes the NAND port delivers a byte in the same cycle it acknowledges.
module pf_fetch #(
    parameter int unsigned CNT_W = 14,
    parameter int unsigned DEPTH = 64,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic             running,
    input  logic [CNT_W-1:0] len,
    input  logic [LVL_W-1:0] fifo_lvl,
    input  logic             nand_ack,
    output logic             nand_req,
    output logic [CNT_W-1:0] remain
);
    // Request while running, bytes owed and FIFO room left.
    always_comb begin
        nand_req = running && (remain != '0) && (fifo_lvl < LVL_W'(DEPTH));
    end

    // Remaining count: cleared on stop, loaded on start, decremented per byte.
    always_ff @(posedge clk) begin
        if (!rst_n || stop) begin
            remain <= '0;
        end else if (start) begin
            remain <= len;
        end else if (nand_req && nand_ack) begin
            remain <= remain - CNT_W'(1);
        end
    end

    // R5
    byte_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nand_req && nand_ack && !stop) |=> (remain == $past(remain) - CNT_W'(1)));
endmodule

// File: rtl/pf_fifo.sv
// Module: pf_fifo
// Byte FIFO with one-byte push and a pop of up to four bytes as a word.
// Assumes DEPTH is a power of two and the writer never pushes when full.
module pf_fifo #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [7:0]       push_data,
    input  logic             pop,
    input  logic             last,
    output logic [LVL_W-1:0] lvl,
    output logic [31:0]      word,
    output logic             word_ok
);
    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [2:0]    take, npop;

    // Word availability and the number of bytes a pop removes.
    always_comb begin
        word_ok = (lvl >= LVL_W'(4)) || (last && (lvl != '0));
        take    = (lvl >= LVL_W'(4)) ? 3'd4 : lvl[2:0];
        npop    = (pop && word_ok) ? take : 3'd0;
    end

    // Head word lanes, zero where the FIFO holds fewer bytes.
    for (genvar i = 0; i < 4; i++) begin : g_lane
        logic [AW-1:0] idx;
        assign idx = rd_ptr + AW'(i);
        assign word[8*i +: 8] = (LVL_W'(i) < lvl) ? mem[idx] : 8'h00;
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Pointers and level.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            lvl    <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(push);
            rd_ptr <= rd_ptr + AW'(npop);
            lvl    <= lvl + LVL_W'(push) - LVL_W'(npop);
        end
    end

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lvl <= LVL_W'(DEPTH));

    // R10
    push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (lvl != LVL_W'(DEPTH)));

    // R6
    pop_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && word_ok && !push && !flush && lvl <= LVL_W'(4)) |=> (lvl == '0));
endmodule

// File: rtl/nand_rd_prefetch.sv
// Module: nand_rd_prefetch (top)
// Register-programmed read prefetch from a byte NAND port to 32-bit host words.
// Assumes a single register master and a host that pops only offered words.
module nand_rd_prefetch
    import pf_pkg::*;
#(
    parameter int unsigned FIFO_BYTES = 64,
    parameter int unsigned CNT_BITS   = 14,
    parameter int unsigned SEL_BITS   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [1:0]          reg_waddr,
    input  logic [31:0]         reg_wdata,
    input  logic [1:0]          reg_raddr,
    output logic [31:0]         reg_rdata,
    input  logic                host_rd,
    output logic [31:0]         host_word,
    output logic                host_word_ok,
    output logic                nand_req,
    input  logic                nand_ack,
    input  logic [7:0]          nand_data,
    output logic [SEL_BITS-1:0] nand_cs
);
    localparam int unsigned LVL_W = $clog2(FIFO_BYTES + 1);

    logic                running, start, stop, dir_q, en_q, err_q;
    logic [LVL_W-1:0]    thr_q, lvl;
    logic [CNT_BITS-1:0] len_q, remain;
    logic                drained, thr_hit;

    pf_regs #(.CNT_W(CNT_BITS), .SEL_W(SEL_BITS), .THR_MAX(FIFO_BYTES)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_waddr),
        .wr_data(reg_wdata), .drained(drained), .running(running),
        .start(start), .stop(stop), .dir_q(dir_q), .en_q(en_q),
        .thr_q(thr_q), .sel_q(nand_cs), .len_q(len_q), .err_q(err_q)
    );

    pf_fetch #(.CNT_W(CNT_BITS), .DEPTH(FIFO_BYTES)) u_fetch (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
        .running(running), .len(len_q), .fifo_lvl(lvl),
        .nand_ack(nand_ack), .nand_req(nand_req), .remain(remain)
    );

    pf_fifo #(.DEPTH(FIFO_BYTES)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(stop),
        .push(nand_req && nand_ack), .push_data(nand_data),
        .pop(host_rd), .last(remain == '0), .lvl(lvl),
        .word(host_word), .word_ok(host_word_ok)
    );

    // Completion and threshold flags.
    always_comb begin
        drained = (remain == '0) && (lvl == '0);
        thr_hit = (thr_q != '0) && (lvl >= thr_q);
    end

    // Register read mux.
    always_comb begin
        reg_rdata = '0;
        case (reg_raddr)
            PF_SETUP: begin
                reg_rdata[DIR_BIT]            = dir_q;
                reg_rdata[EN_BIT]             = en_q;
                reg_rdata[THR_LSB +: LVL_W]   = thr_q;
                reg_rdata[SEL_LSB +: SEL_BITS] = nand_cs;
            end
            PF_LEN:  reg_rdata[CNT_BITS-1:0] = len_q;
            PF_CTRL: reg_rdata[0] = running;
            default: begin
                reg_rdata[CNT_BITS-1:0]     = remain;
                reg_rdata[LVL_LSB +: LVL_W] = lvl;
                reg_rdata[ERR_BIT]          = err_q;
                reg_rdata[HIT_BIT]          = thr_hit;
            end
        endcase
    end

    // R8
    idle_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && remain == '0 && lvl == '0 && !start) |=> !running);

    // R6
    word_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_word_ok |-> (lvl != '0));

    // R5
    idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !nand_req);
endmodule

// File: tb/nand_rd_prefetch_tb.sv
module nand_rd_prefetch_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [1:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        host_rd = 1'b0;
    logic [31:0] host_word;
    logic        host_word_ok;
    logic        nand_req;
    logic        nand_ack = 1'b0;
    logic [7:0]  nand_data;
    logic [2:0]  nand_cs;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int unsigned nidx = 0;
    int ack_pct = 100;
    logic [7:0] nbase = 8'h00;
    logic pend = 1'b0;

    always #5 clk = ~clk;

    nand_rd_prefetch u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .host_rd(host_rd), .host_word(host_word), .host_word_ok(host_word_ok),
        .nand_req(nand_req), .nand_ack(nand_ack), .nand_data(nand_data),
        .nand_cs(nand_cs)
    );

    function automatic logic [7:0] pat(logic [7:0] b, int k);
        return b + 8'(k * 29);
    endfunction

    function automatic logic [31:0] stat_exp(int rem, int lvl, bit err, int thr);
        logic [31:0] s = '0;
        s[13:0]  = 14'(rem);
        s[30:24] = 7'(lvl);
        s[15]    = err;
        s[14]    = (thr != 0) && (lvl >= thr);
        return s;
    endfunction

    assign nand_data = pat(nbase, nidx);

    // NAND model: a byte counts once the edge it was accepted on has passed.
    always @(negedge clk) begin
        if (pend) nidx++;
        nand_ack = ($urandom % 100) < ack_pct;
        pend = nand_req && nand_ack;
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        #1;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        reg_raddr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic run_xfer(int len, int ackp, int popp, int hold, logic [2:0] sel, bit full_chk);
        logic [31:0] v, w;
        int k = 0;
        int guard = 0;
        wr(2'd1, 32'(len));
        wr(2'd0, {5'b0, sel, 8'h00, 8'd16, 8'h80});
        nbase = 8'($urandom);
        nidx = 0;
        ack_pct = ackp;
        wr(2'd2, 32'd1);
        rd(2'd2, v);
        chk("R3 start ctrl", v, 32'd1);
        while (k < len && guard < 20000) begin
            @(negedge clk);
            host_rd = 1'b0;
            #2;
            guard++;
            rd(2'd3, v);
            chk("R7 status in flight", v, stat_exp(len - int'(nidx), int'(nidx) - k, 1'b0, 16));
            chk("R5 chip select", 32'(nand_cs), 32'(sel));
            if (full_chk && guard == hold) begin
                chk("R10 level at full", 32'(v[30:24]), 32'd64);
                chk("R10 request paused", 32'(nand_req), 32'd0);
            end
            if (host_word_ok && guard > hold && int'($urandom % 100) < popp) begin
                for (int b = 0; b < 4; b++)
                    w[8*b +: 8] = (k + b < len) ? pat(nbase, k + b) : 8'h00;
                chk("R6 host word", host_word, w);
                host_rd = 1'b1;
                k += 4;
            end
        end
        if (guard >= 20000) chk("R6 transfer finished", 32'(k), 32'(len));
        @(negedge clk);
        host_rd = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        rd(2'd2, v);
        chk("R8 idle after drain", v, 32'd0);
        rd(2'd3, v);
        chk("R8 status after drain", v, 32'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        ack_pct = 100;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 reset value", v, 32'd0);
        end
        chk("R6 no word after reset", 32'(host_word_ok), 32'd0);

        // R1 field readback, upper chip-select bits dropped
        wr(2'd0, 32'hFD00_4081);
        rd(2'd0, v);
        chk("R1 setup readback", v, 32'h0500_4081);
        wr(2'd1, 32'hFFFF_C123);
        rd(2'd1, v);
        chk("R1 length readback", v, 32'h0000_0123);

        // R3 direction bit set: start ignored
        wr(2'd2, 32'd1);
        rd(2'd2, v);
        chk("R3 write direction blocks start", v, 32'd0);
        rd(2'd3, v);
        chk("R3 no load on refused start", v, 32'd0);

        // R2 threshold above 64 refused
        wr(2'd0, 32'h0000_4180);
        rd(2'd0, v);
        chk("R2 setup unchanged", v, 32'h0500_4081);
        rd(2'd3, v);
        chk("R2 error flagged", v, 32'h0000_8000);

        // R9 stop clears the error
        wr(2'd2, 32'd0);
        rd(2'd3, v);
        chk("R9 error cleared", v, 32'd0);

        // R3 enable clear: start ignored
        wr(2'd0, 32'h0000_1000);
        wr(2'd1, 32'd8);
        wr(2'd2, 32'd1);
        rd(2'd2, v);
        chk("R3 disabled start ignored", v, 32'd0);

        // R8 zero-length transfer
        wr(2'd1, 32'd0);
        wr(2'd0, 32'h0000_0080);
        wr(2'd2, 32'd1);
        rd(2'd2, v);
        chk("R3 zero length started", v, 32'd1);
        @(negedge clk);
        #1;
        rd(2'd2, v);
        chk("R8 zero length idles next cycle", v, 32'd0);

        // Directed: short partial word, then FIFO full with no reads
        run_xfer(6, 100, 100, 0, 3'd2, 1'b0);
        run_xfer(100, 100, 100, 80, 3'd7, 1'b1);

        // Constrained random transfers
        for (int t = 0; t < 6; t++)
            run_xfer(1 + int'($urandom % 150), 30 + int'($urandom % 71),
                     20 + int'($urandom % 81), 0, 3'($urandom), 1'b0);

        // R4 busy writes refused, then R9 stop
        ack_pct = 100;
        wr(2'd1, 32'd200);
        wr(2'd0, 32'h0300_1080);
        wr(2'd2, 32'd1);
        wr(2'd1, 32'd5);
        rd(2'd1, v);
        chk("R4 length kept while busy", v, 32'd200);
        wr(2'd0, 32'h0000_2080);
        rd(2'd0, v);
        chk("R4 setup kept while busy", v, 32'h0300_1080);
        rd(2'd3, v);
        chk("R4 sticky error", 32'(v[15]), 32'd1);
        wr(2'd2, 32'd1);
        rd(2'd2, v);
        chk("R3 start while busy no effect", v, 32'd1);
        wr(2'd2, 32'd0);
        rd(2'd2, v);
        chk("R9 stopped", v, 32'd0);
        rd(2'd3, v);
        chk("R9 status cleared", v, 32'd0);
        chk("R9 no word after stop", 32'(host_word_ok), 32'd0);
        chk("R9 no request after stop", 32'(nand_req), 32'd0);

        // R6 read with no word available is ignored
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        #1;
        rd(2'd3, v);
        chk("R6 empty read ignored", v, 32'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule